// File: doc/BRIEF.md
# Refresh Configuration Register Unit

This block sits on the device side of an asynchronous memory bus. It holds the 16-bit word that sets how the memory core refreshes itself, and it decides when a bus access is really an access to that word and not to the array. The bus pins (chip select, write strobe, read strobe, sleep pin, address and write data) are registered once on the system clock. Access boundaries are then found by comparing the current sample with the previous one. A read ends when the read condition drops or the address moves. A write ends at the first rise of chip select or write strobe.

There are two ways to load the word. In the pin path, the sleep pin falls and a write then completes while it stays low; the low 16 address bits become the new value. In the unlock path, the host makes four accesses in a row to the highest address: two reads, a write of zero, and then a final access. If the final access is a write, its data loads the word. If it is a read, the word is driven back on the data bus. The sequencer has five states: `SQ_IDLE`, `SQ_RD1` (one top read seen), `SQ_RD2` (two seen), `SQ_ARMED` (zero written) and `SQ_BLOCK` (cancelled). Its transitions are these. IDLE goes to RD1 on a top read. RD1 goes to RD2 on a top read. RD2 goes to BLOCK on a top read and to ARMED on a top write of zero. ARMED goes back to IDLE on any access, loading on a top write. BLOCK goes to IDLE only on a read of another address. Any other access from RD1 or RD2 returns to IDLE. The sequencer ignores accesses made while the sleep pin is low.

Top module: `refresh_cfg_unit`

## Requirements
- R1: After reset the word is 0x0080, the software-load flag is 0 and the data-bus drive enable is 0.
- R2: After the sleep pin falls, a write that ends while the pin is still low loads address bits 15:0 into the word.
- R3: A read made while the sleep pin is low leaves the word unchanged, because the pin path only accepts writes.
- R4: Top-address read, top read, top write of 0x0000, then a top write of D, loads D into the word (bit 4 excepted, see R11) and sets the software-load flag.
- R5: If the fourth access of that sequence is a top read, data-out shows the word and drive enable is 1 during that read. The word and the flag stay unchanged.
- R6: A third consecutive top read cancels the sequence. Only a read of a different address ends the cancel; writes elsewhere do not.
- R7: An access to another address, or a write out of order or with non-zero data in place of the zero write, returns the sequencer to idle without loading.
- R8: The array-inhibit output is 1 during the zero write, during the fourth access and during a pin-path write, and 0 during ordinary accesses.
- R9: The partial-array field is word bits 2:0, the sleep-mode output is bit 4 (1 = partial array, 0 = deep power-down) and the page-mode output is bit 7.
- R10: The software-load flag stays set through later pin-path loads and clears only on reset.
- R11: A software load keeps word bit 4 at its previous value. Only the pin path can change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| sleep_n | input | 1 | Sleep pin, active low |
| addr | input | 20 | Bus address |
| dq_in | input | 16 | Write data from the bus |
| dq_out | output | 16 | Word value for readback |
| dq_oe | output | 1 | Drive dq_out onto the bus |
| array_inhibit | output | 1 | Current access must not touch the array |
| cfg_q | output | 16 | Configuration word |
| par_sel | output | 3 | Partial-array size field |
| sleep_par | output | 1 | Sleep-mode select |
| page_en | output | 1 | Page-read enable |
| sw_loaded | output | 1 | A software load has happened since reset |

## Verification
Directed runs cover each sequence shape on its own. These are the full load and the readback (which differ only in the type of the fourth access), the triple-read cancel with its release by a foreign read, and broken orders that must fall back to idle. A separate run checks that a zero write and a non-zero write are told apart. Pin-path writes and reads separate R2 from R3, and loads that try to flip bit 4 separate R11. A seeded random stream, mostly aimed at the top address with zero data, then mixes reads, writes and pin-path loads. A bench model predicts the word, the flag and the readback after every access.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_RD1,
        SQ_RD2,
        SQ_ARMED,
        SQ_BLOCK
    } seq_state_t;
endpackage

// File: rtl/rcr_bus_sampler.sv
module rcr_bus_sampler #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              sleep_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_end,
    output logic              wr_end,
    output logic [ADDR_W-1:0] ev_addr,
    output logic [DATA_W-1:0] ev_data,
    output logic              cur_rd,
    output logic              cur_wr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_data,
    output logic              sleep_low,
    output logic              sleep_fall
);
    logic              s_cs_n, s_we_n, s_oe_n, s_sleep_n;
    logic              p_cs_n, p_we_n, p_oe_n, p_sleep_n;
    logic [ADDR_W-1:0] s_addr, p_addr;
    logic [DATA_W-1:0] s_data, p_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_cs_n <= 1'b1; s_we_n <= 1'b1; s_oe_n <= 1'b1; s_sleep_n <= 1'b0;
            p_cs_n <= 1'b1; p_we_n <= 1'b1; p_oe_n <= 1'b1; p_sleep_n <= 1'b0;
            s_addr <= '0; p_addr <= '0;
            s_data <= '0; p_data <= '0;
        end else begin
            s_cs_n <= cs_n; s_we_n <= we_n; s_oe_n <= oe_n; s_sleep_n <= sleep_n;
            s_addr <= addr; s_data <= dq_in;
            p_cs_n <= s_cs_n; p_we_n <= s_we_n; p_oe_n <= s_oe_n; p_sleep_n <= s_sleep_n;
            p_addr <= s_addr; p_data <= s_data;
        end
    end

    logic prv_rd, prv_wr;
    always_comb begin
        cur_rd     = !s_cs_n && s_we_n && !s_oe_n;
        cur_wr     = !s_cs_n && !s_we_n;
        prv_rd     = !p_cs_n && p_we_n && !p_oe_n;
        prv_wr     = !p_cs_n && !p_we_n;
        rd_end     = prv_rd && (!cur_rd || (s_addr != p_addr));
        wr_end     = prv_wr && !cur_wr;
        ev_addr    = p_addr;
        ev_data    = p_data;
        cur_addr   = s_addr;
        cur_data   = s_data;
        sleep_low  = !s_sleep_n;
        sleep_fall = p_sleep_n && !s_sleep_n;
    end

    // a read and a write can never end on the same sample
    p_excl_end_r7: assert property (@(posedge clk) disable iff (!rst_n) !(rd_end && wr_end));
endmodule

// File: rtl/rcr_seq_fsm.sv
module rcr_seq_fsm
    import rcr_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_en,
    input  logic              rd_end,
    input  logic              wr_end,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] ev_data,
    output seq_state_t        state,
    output logic              sw_load
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    seq_state_t nxt;
    logic rd, wr, hit, zero;

    always_comb begin
        rd   = rd_end && seq_en;
        wr   = wr_end && seq_en;
        hit  = (ev_addr == TOP_ADDR);
        zero = (ev_data == '0);
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SQ_IDLE:  if (rd && hit) nxt = SQ_RD1;
            SQ_RD1: begin
                if (rd && hit)      nxt = SQ_RD2;
                else if (rd || wr)  nxt = SQ_IDLE;
            end
            SQ_RD2: begin
                if (rd && hit)               nxt = SQ_BLOCK;
                else if (wr && hit && zero)  nxt = SQ_ARMED;
                else if (rd || wr)           nxt = SQ_IDLE;
            end
            SQ_ARMED: if (rd || wr) nxt = SQ_IDLE;
            SQ_BLOCK: if (rd && !hit) nxt = SQ_IDLE;
            default:  nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        sw_load = (state == SQ_ARMED) && wr && hit;
    end

    p_armed_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_ARMED && $past(state) != SQ_ARMED) |-> $past(state) == SQ_RD2);
    p_block_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_BLOCK && !(rd_end && seq_en && ev_addr != TOP_ADDR)) |=> state == SQ_BLOCK);
    p_idle_on_foreign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SQ_BLOCK && seq_en && (rd_end || wr_end) && ev_addr != TOP_ADDR) |=> state == SQ_IDLE);
endmodule

// File: rtl/refresh_cfg_unit.sv
module refresh_cfg_unit
    import rcr_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int REG_W     = 16,
    parameter int PAR_W     = 3,
    parameter int SLEEP_BIT = 4,
    parameter int PAGE_BIT  = 7,
    parameter logic [REG_W-1:0] RESET_VAL = 16'h0080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              sleep_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  dq_in,
    output logic [REG_W-1:0]  dq_out,
    output logic              dq_oe,
    output logic              array_inhibit,
    output logic [REG_W-1:0]  cfg_q,
    output logic [PAR_W-1:0]  par_sel,
    output logic              sleep_par,
    output logic              page_en,
    output logic              sw_loaded
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    logic              rd_end, wr_end, cur_rd, cur_wr, sleep_low, sleep_fall;
    logic [ADDR_W-1:0] ev_addr, cur_addr;
    logic [REG_W-1:0]  ev_data, cur_data;
    seq_state_t        seq_state;
    logic              sw_load, zz_load, zz_arm;

    rcr_bus_sampler #(.ADDR_W(ADDR_W), .DATA_W(REG_W)) u_smp (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .sleep_n(sleep_n), .addr(addr), .dq_in(dq_in),
        .rd_end(rd_end), .wr_end(wr_end), .ev_addr(ev_addr), .ev_data(ev_data),
        .cur_rd(cur_rd), .cur_wr(cur_wr), .cur_addr(cur_addr), .cur_data(cur_data),
        .sleep_low(sleep_low), .sleep_fall(sleep_fall)
    );

    rcr_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(REG_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .seq_en(!sleep_low),
        .rd_end(rd_end), .wr_end(wr_end), .ev_addr(ev_addr), .ev_data(ev_data),
        .state(seq_state), .sw_load(sw_load)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          zz_arm <= 1'b0;
        else if (sleep_fall) zz_arm <= 1'b1;
        else if (!sleep_low) zz_arm <= 1'b0;
    end

    always_comb zz_load = sleep_low && zz_arm && wr_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= RESET_VAL;
            sw_loaded <= 1'b0;
        end else if (zz_load) begin
            cfg_q <= ev_addr[REG_W-1:0];
        end else if (sw_load) begin
            for (int i = 0; i < REG_W; i++)
                cfg_q[i] <= (i == SLEEP_BIT) ? cfg_q[i] : ev_data[i];
            sw_loaded <= 1'b1;
        end
    end

    always_comb begin
        par_sel   = cfg_q[PAR_W-1:0];
        sleep_par = cfg_q[SLEEP_BIT];
        page_en   = cfg_q[PAGE_BIT];
        dq_oe     = !sleep_low && cur_rd && (cur_addr == TOP_ADDR) && (seq_state == SQ_ARMED);
        dq_out    = dq_oe ? cfg_q : '0;
        if (sleep_low)
            array_inhibit = cur_wr;
        else
            array_inhibit = (cur_addr == TOP_ADDR) &&
                            ((seq_state == SQ_ARMED && (cur_rd || cur_wr)) ||
                             (seq_state == SQ_RD2 && cur_wr && cur_data == '0));
    end

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_loaded |=> sw_loaded);
    p_bit4_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_load && !zz_load) |=> cfg_q[SLEEP_BIT] == $past(cfg_q[SLEEP_BIT]));
    p_sleep_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_low && rd_end) |=> $stable(cfg_q));
    p_flag_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_loaded) |-> $past(seq_state) == SQ_ARMED);
    p_oe_no_inhibit_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> array_inhibit);
endmodule

// File: tb/refresh_cfg_unit_test.sv
module refresh_cfg_unit_test;
    localparam int TOP = 20'hFFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, sleep_n = 1'b1;
    logic [19:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out, cfg_q;
    logic        dq_oe, array_inhibit, sleep_par, page_en, sw_loaded;
    logic [2:0]  par_sel;

    int checks = 0, errors = 0, cycles = 0;
    logic [15:0] cap_out;
    logic        cap_oe, cap_inh;

    // bench model: 0 idle, 1 one read, 2 two reads, 3 armed, 4 blocked
    int          mst;
    logic [15:0] mreg;
    logic        mflag;

    always #4 clk = ~clk;

    refresh_cfg_unit uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .sleep_n(sleep_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .array_inhibit(array_inhibit), .cfg_q(cfg_q),
        .par_sel(par_sel), .sleep_par(sleep_par), .page_en(page_en),
        .sw_loaded(sw_loaded)
    );

    always @(posedge clk) cycles++;

    initial begin
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int model_next(input int st, input bit wr, input bit hit, input bit zero);
        case (st)
            0: return (!wr && hit) ? 1 : 0;
            1: return (!wr && hit) ? 2 : 0;
            2: return (!wr && hit) ? 4 : ((wr && hit && zero) ? 3 : 0);
            3: return 0;
            default: return (!wr && !hit) ? 0 : 4;
        endcase
    endfunction

    task automatic model_access(input bit wr, input logic [19:0] a, input logic [15:0] d);
        if (mst == 3 && wr && a == TOP) begin
            mreg  = {d[15:5], mreg[4], d[3:0]};
            mflag = 1'b1;
        end
        mst = model_next(mst, wr, a == TOP, d == 16'h0);
    endtask

    task automatic do_read(input logic [19:0] a);
        @(negedge clk);
        addr = a; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        repeat (3) @(negedge clk);
        cap_oe = dq_oe; cap_out = dq_out; cap_inh = array_inhibit;
        cs_n = 1'b1; oe_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_write(input logic [19:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; dq_in = d; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        repeat (3) @(negedge clk);
        cap_oe = dq_oe; cap_inh = array_inhibit;
        we_n = 1'b1; cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic pin_load(input logic [19:0] a);
        @(negedge clk); sleep_n = 1'b0;
        repeat (3) @(negedge clk);
        do_write(a, 16'hDEAD);
        sleep_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        mst = 0; mreg = 16'h0080; mflag = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        do_reset();
        // R1, R9 reset state and field decode
        chk("R1 cfg", cfg_q, 16'h0080);
        chk("R1 flag", sw_loaded, 0);
        chk("R1 oe", dq_oe, 0);
        chk("R9 page", page_en, 1);
        chk("R9 sleep", sleep_par, 0);
        chk("R9 par", par_sel, 0);

        // R2 pin-path load, R8 inhibit on that write
        @(negedge clk); sleep_n = 1'b0;
        repeat (3) @(negedge clk);
        do_write(20'h12345, 16'h0000);
        chk("R8 pin write inhibit", cap_inh, 1);
        chk("R2 pin load", cfg_q, 16'h2345);
        chk("R9 par after load", par_sel, 3'd5);
        chk("R9 page after load", page_en, 0);
        // R3 read under sleep does not load
        do_read(20'h0ABCD);
        chk("R3 sleep read", cfg_q, 16'h2345);
        sleep_n = 1'b1;
        repeat (3) @(negedge clk);
        mreg = 16'h2345;

        // R5 readback
        do_read(TOP); do_read(TOP);
        do_write(TOP, 16'h0000);
        chk("R8 zero write inhibit", cap_inh, 1);
        do_read(TOP);
        chk("R5 oe", cap_oe, 1);
        chk("R5 data", cap_out, 16'h2345);
        chk("R8 readback inhibit", cap_inh, 1);
        chk("R5 cfg kept", cfg_q, 16'h2345);
        chk("R5 no flag", sw_loaded, 0);

        // R4 software load, R11 bit 4 kept (old 0, new 1)
        do_read(TOP); do_read(TOP); do_write(TOP, 16'h0000);
        do_write(TOP, 16'h0093);
        chk("R4 load", cfg_q, 16'h0083);
        chk("R11 bit4", sleep_par, 0);
        chk("R4 flag", sw_loaded, 1);

        // R6 cancel by third read
        do_read(TOP); do_read(TOP); do_read(TOP);
        do_write(TOP, 16'h0000); do_write(TOP, 16'h5555);
        chk("R6 cancelled", cfg_q, 16'h0083);
        do_write(20'h00010, 16'h1111);
        do_read(TOP); do_read(TOP); do_write(TOP, 16'h0000); do_write(TOP, 16'h5555);
        chk("R6 still blocked", cfg_q, 16'h0083);
        do_read(20'h00020);
        do_read(TOP); do_read(TOP); do_write(TOP, 16'h0000); do_write(TOP, 16'h5545);
        chk("R6 released", cfg_q, 16'h5545);

        // R7 broken orders
        do_read(TOP); do_read(20'h00001); do_read(TOP); do_write(TOP, 16'h0000);
        do_write(TOP, 16'h00AA);
        chk("R7 foreign read", cfg_q, 16'h5545);
        do_read(TOP); do_read(TOP); do_write(TOP, 16'h0005);
        chk("R8 nonzero no inhibit", cap_inh, 0);
        do_write(TOP, 16'h00AA);
        chk("R7 nonzero third", cfg_q, 16'h5545);
        do_read(20'h00100);
        chk("R8 normal read", cap_inh, 0);

        // R10 flag survives pin load; R11 pin path may set bit 4
        pin_load(20'h00010);
        chk("R11 pin sets bit4", sleep_par, 1);
        chk("R10 flag kept", sw_loaded, 1);

        // random phase
        do_reset();
        for (int n = 0; n < 600; n++) begin
            int kind;
            logic [19:0] a;
            logic [15:0] d;
            kind = $urandom % 16;
            a = (($urandom % 4) == 0) ? 20'($urandom) : 20'(TOP);
            d = (($urandom % 2) == 0) ? 16'h0 : 16'($urandom);
            if (kind == 0) begin
                pin_load(a);
                mreg = a[15:0];
            end else if (kind < 9) begin
                bit exp_oe;
                exp_oe = (mst == 3) && (a == TOP);
                do_read(a);
                chk("R5 rand oe", cap_oe, exp_oe);
                if (exp_oe) chk("R5 rand data", cap_out, mreg);
                model_access(1'b0, a, d);
            end else begin
                do_write(a, d);
                model_access(1'b1, a, d);
            end
            chk("R4 rand cfg", cfg_q, mreg);
            chk("R10 rand flag", sw_loaded, mflag);
        end

        do_reset();
        chk("R10 reset clears", sw_loaded, 0);
        chk("R1 cfg after reset", cfg_q, 16'h0080);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule